// File: doc/BRIEF.md
# Single-Pass Spatial Tile Binner

This block takes a stream of samples, each with a 2-D position and a data word, and sorts them coarsely by spatial tile in one pass. A translation stage registers each sample together with its tile number. A mapping stage then places the sample in a small per-tile buffer. When a tile has collected a full group, the block writes that group to memory as one fixed-length burst. The burst carries the samples followed by a link to the group that tile wrote before. Each tile's groups therefore form a chain that runs backwards through memory.

When the last sample of a frame has been handled, the block scans the tiles in ascending order. It writes out every partly filled group, with a count of the valid samples in it. It then writes a head table: one entry per tile, holding the address of that tile's newest group. A later stage can start from any table entry and follow the links to visit every sample of that tile, with no second sorting pass.

Top module: `tile_binner`

## Requirements
- R1: The tile of a sample is (y >> 3) * 8 + (x >> 3) for the 6-bit coordinates x and y, which gives 64 tiles numbered 0 to 63.
- R2: No burst is issued for a tile until it holds 4 samples. The 4th sample starts a burst of 5 beats with m_map = 0. Beats 0 to 3 carry the samples in arrival order. Beat 4 carries the link and is the only beat with m_last = 1. Every beat has m_count = 4.
- R3: Groups occupy consecutive word addresses. The first group after reset has base 0. Each later group's base is 5 above the previous one, including across frames. Beat k of a group is at address base + k.
- R4: The link beat holds the base address of the previous group of the same tile in the current frame, or 16'hFFFF if there is none.
- R5: While an output beat is pending (m_valid = 1), s_ready is low and no input sample is taken.
- R6: After the sample with s_eof = 1, and after any full group that sample completes, every tile with 1 to 3 buffered samples is flushed in ascending tile order. Each flush is still a 5-beat burst and carries m_count equal to the number of valid samples. Data beats beyond that count read 0.
- R7: After the flush, a head-table burst of 64 beats is issued with m_map = 1. Beat i has address i and data equal to the base of tile i's newest group, or 16'hFFFF if the tile has none. m_last is set on beat 63 only.
- R8: After reset, and again after each head-table burst, every tile is empty and has no previous group. Right after reset, s_ready = 1 and m_valid = 0.
- R9: While m_valid = 1 and m_ready = 0, m_valid stays high and m_addr, m_data and m_last hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can take a sample |
| s_x | input | 6 | Sample X coordinate |
| s_y | input | 6 | Sample Y coordinate |
| s_data | input | 16 | Sample payload |
| s_eof | input | 1 | Marks the last sample of a frame |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Memory side accepts the beat |
| m_addr | output | 16 | Word address of the beat |
| m_data | output | 16 | Sample, link or head-table word |
| m_last | output | 1 | Final beat of a burst |
| m_map | output | 1 | Beat belongs to the head table |
| m_count | output | 3 | Valid samples in the current group |

## Verification
The bench checks a tile that fills twice and is then flushed partly full. A design that mis-handles this would give the wrong links or count, or would show stale samples where it should show zeros. It also sends an end-of-frame marker on a sample that completes a group. A wrong design could skip the full burst, skip the flush, or flush the same tile twice. A second frame shows whether links and the head table are cleared between frames, and whether the base address keeps counting across the frame edge. A long pseudo-random frame with a stalling m_ready shows whether beats are dropped, whether outputs change while stalled, and whether input is taken during a burst.

// File: rtl/tile_binner.sv
module tile_binner #(
  parameter int COORD_W    = 6,
  parameter int TILE_SHIFT = 3,
  parameter int GROUP_P    = 4,
  parameter int W          = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           s_valid,
  output logic                           s_ready,
  input  logic [COORD_W-1:0]             s_x,
  input  logic [COORD_W-1:0]             s_y,
  input  logic [W-1:0]                   s_data,
  input  logic                           s_eof,
  output logic                           m_valid,
  input  logic                           m_ready,
  output logic [W-1:0]                   m_addr,
  output logic [W-1:0]                   m_data,
  output logic                           m_last,
  output logic                           m_map,
  output logic [$clog2(GROUP_P+1)-1:0]   m_count
);
  localparam int TB     = COORD_W - TILE_SHIFT;
  localparam int NTILES = 1 << (2 * TB);
  localparam int TW     = 2 * TB;
  localparam int CW     = $clog2(GROUP_P + 1);
  localparam int MI     = $clog2(NTILES * GROUP_P);
  localparam logic [CW-1:0] LASTBEAT = CW'(GROUP_P);
  localparam logic [CW-1:0] FULLM1   = CW'(GROUP_P - 1);
  localparam logic [TW-1:0] LASTT    = TW'(NTILES - 1);
  localparam logic [W-1:0]  NULLP    = '1;

  typedef enum logic [1:0] {RUN, BURST, SCAN, MAP} st_t;
  st_t st;

  logic          t_valid, t_eof;
  logic [TW-1:0] t_tile;
  logic [W-1:0]  t_data;

  logic          eof_pend, flushing;
  logic [TW-1:0] cur, idx;
  logic [CW-1:0] beat;
  logic [W-1:0]  wptr;
  logic [CW-1:0] cnt  [NTILES];
  logic [W-1:0]  head [NTILES];
  logic [W-1:0]  mem  [NTILES*GROUP_P];

  assign s_ready = (st == RUN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_valid <= 1'b0;
      t_eof   <= 1'b0;
      t_tile  <= '0;
      t_data  <= '0;
    end else if (st == RUN) begin
      t_valid <= s_valid;
      if (s_valid) begin
        t_tile <= {s_y[COORD_W-1:TILE_SHIFT], s_x[COORD_W-1:TILE_SHIFT]};
        t_data <= s_data;
        t_eof  <= s_eof;
      end
    end
  end

  logic [CW-1:0] slot;
  logic          take;
  logic [MI-1:0] wa;
  assign slot = cnt[t_tile];
  assign take = (st == RUN) && t_valid;
  assign wa   = MI'(t_tile) * MI'(GROUP_P) + MI'(slot);

  always_ff @(posedge clk) begin
    if (take) mem[wa] <= t_data;
  end

  logic burst_done, map_done;
  assign burst_done = (st == BURST) && m_ready && (beat == LASTBEAT);
  assign map_done   = (st == MAP) && m_ready && (idx == LASTT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= RUN;
      eof_pend <= 1'b0;
      flushing <= 1'b0;
      cur      <= '0;
      idx      <= '0;
      beat     <= '0;
      wptr     <= '0;
      for (int i = 0; i < NTILES; i++) begin
        cnt[i]  <= '0;
        head[i] <= NULLP;
      end
    end else begin
      case (st)
        RUN: if (t_valid) begin
          cnt[t_tile] <= slot + 1'b1;
          if (slot == FULLM1) begin
            st       <= BURST;
            cur      <= t_tile;
            beat     <= '0;
            eof_pend <= t_eof;
            flushing <= 1'b0;
          end else if (t_eof) begin
            st       <= SCAN;
            idx      <= '0;
            flushing <= 1'b1;
          end
        end
        BURST: if (m_ready) begin
          if (burst_done) begin
            head[cur] <= wptr;
            cnt[cur]  <= '0;
            wptr      <= wptr + W'(GROUP_P + 1);
            if (flushing) begin
              if (idx == LASTT) begin
                st  <= MAP;
                idx <= '0;
              end else begin
                st  <= SCAN;
                idx <= idx + 1'b1;
              end
            end else if (eof_pend) begin
              st       <= SCAN;
              idx      <= '0;
              flushing <= 1'b1;
              eof_pend <= 1'b0;
            end else begin
              st <= RUN;
            end
          end else begin
            beat <= beat + 1'b1;
          end
        end
        SCAN: begin
          if (cnt[idx] != '0) begin
            st   <= BURST;
            cur  <= idx;
            beat <= '0;
          end else if (idx == LASTT) begin
            st  <= MAP;
            idx <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        MAP: if (m_ready) begin
          if (map_done) begin
            st       <= RUN;
            flushing <= 1'b0;
            for (int i = 0; i < NTILES; i++) begin
              cnt[i]  <= '0;
              head[i] <= NULLP;
            end
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: st <= RUN;
      endcase
    end
  end

  logic [MI-1:0] ra;
  assign ra = MI'(cur) * MI'(GROUP_P) + MI'(beat);

  assign m_valid = (st == BURST) || (st == MAP);
  assign m_map   = (st == MAP);
  assign m_last  = (st == BURST) ? (beat == LASTBEAT) : (st == MAP) && (idx == LASTT);
  assign m_count = (st == BURST) ? cnt[cur] : '0;
  assign m_addr  = (st == BURST) ? wptr + W'(beat) : W'(idx);

  always_comb begin
    m_data = '0;
    if (st == MAP)                     m_data = head[idx];
    else if (st == BURST) begin
      if (beat == LASTBEAT)            m_data = head[cur];
      else if (beat < cnt[cur])        m_data = mem[ra];
    end
  end

  assert_no_input_in_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !s_ready);
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_addr) && $stable(m_data) && $stable(m_last));
  assert_count_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_map |-> (m_count != '0) && (m_count <= LASTBEAT));
  assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_ready && !m_last && !m_map |=> m_valid && (m_addr == $past(m_addr) + 1'b1));
  assert_map_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_ready && m_last && m_map |=> !m_valid && s_ready);
endmodule

// File: tb/tile_binner_tb_top.sv
`timescale 1ns/1ps
module tile_binner_tb_top;
  logic clk = 0, rst_n = 0;
  logic s_valid = 0, s_ready, s_eof = 0;
  logic [5:0] s_x = 0, s_y = 0;
  logic [15:0] s_data = 0;
  logic m_valid, m_ready = 1, m_last, m_map;
  logic [15:0] m_addr, m_data;
  logic [2:0] m_count;

  tile_binner dut_i (.clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_x(s_x), .s_y(s_y), .s_data(s_data), .s_eof(s_eof), .m_valid(m_valid),
    .m_ready(m_ready), .m_addr(m_addr), .m_data(m_data), .m_last(m_last),
    .m_map(m_map), .m_count(m_count));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;
  string extra = "";

  int n_exp = 0, n_act = 0;
  logic        e_map [4096], a_map [4096], e_last [4096], a_last [4096];
  logic [15:0] e_addr[4096], a_addr[4096], e_data[4096], a_data[4096];
  logic [2:0]  e_cnt [4096], a_cnt [4096];

  int          m_cnt_t [64];
  logic [15:0] m_head  [64];
  logic [15:0] m_buf   [64][4];
  logic [15:0] m_wptr = 0;

  bit bp_on = 0;
  int r5_viol = 0;
  bit prev_stall = 0;
  logic [15:0] p_addr, p_data;
  logic p_last;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        checks++;
        if (!m_valid || m_addr != p_addr || m_data != p_data || m_last != p_last) begin
          fails++;
          $display("FAIL R9 stall hold: act v=%0b a=%h d=%h l=%0b exp v=1 a=%h d=%h l=%0b",
                   m_valid, m_addr, m_data, m_last, p_addr, p_data, p_last);
        end
      end
      if (m_valid && s_ready) r5_viol++;
    end
    m_ready = bp_on ? (($urandom % 3) != 0) : 1'b1;
    prev_stall = rst_n && m_valid && !m_ready;
    p_addr = m_addr; p_data = m_data; p_last = m_last;
    if (rst_n && m_valid && m_ready && n_act < 4096) begin
      a_map[n_act] = m_map; a_last[n_act] = m_last; a_addr[n_act] = m_addr;
      a_data[n_act] = m_data; a_cnt[n_act] = m_count;
      n_act++;
    end
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: act %h exp %h", req, what, act, exp);
    end
  endtask

  task automatic emit(logic mp, logic [15:0] a, logic [15:0] d, logic l, logic [2:0] c);
    e_map[n_exp] = mp; e_addr[n_exp] = a; e_data[n_exp] = d; e_last[n_exp] = l; e_cnt[n_exp] = c;
    n_exp++;
  endtask

  task automatic model_clear();
    for (int i = 0; i < 64; i++) begin m_cnt_t[i] = 0; m_head[i] = 16'hFFFF; end
  endtask

  task automatic model_group(int t);
    logic [15:0] base = m_wptr;
    for (int k = 0; k < 4; k++)
      emit(0, base + 16'(k), (k < m_cnt_t[t]) ? m_buf[t][k] : 16'h0, 0, 3'(m_cnt_t[t]));
    emit(0, base + 16'd4, m_head[t], 1, 3'(m_cnt_t[t]));
    m_head[t] = base; m_cnt_t[t] = 0; m_wptr = m_wptr + 16'd5;
  endtask

  task automatic send(int x, int y, logic [15:0] d, bit eof);
    int t = (y >> 3) * 8 + (x >> 3);
    m_buf[t][m_cnt_t[t]] = d;
    m_cnt_t[t]++;
    if (m_cnt_t[t] == 4) model_group(t);
    if (eof) begin
      for (int i = 0; i < 64; i++) if (m_cnt_t[i] != 0) model_group(i);
      for (int i = 0; i < 64; i++) emit(1, 16'(i), m_head[i], i == 63, 0);
      model_clear();
    end
    @(negedge clk);
    s_valid = 1; s_x = 6'(x); s_y = 6'(y); s_data = d; s_eof = eof;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 0; s_eof = 0;
  endtask

  task automatic compare(string name);
    int guard = 0;
    while (n_act < n_exp && guard < 20000) begin @(negedge clk); guard++; end
    repeat (20) @(negedge clk);
    chk(n_act == n_exp, "R2,R6", {name, " beat total"}, n_act, n_exp);
    for (int i = 0; i < n_exp && i < n_act; i++) begin
      string rq;
      if (e_map[i]) rq = "R1 R7";
      else if (e_last[i]) rq = (extra != "") ? "R4 R8" : "R4";
      else if (e_cnt[i] != 3'd4) rq = "R6";
      else rq = "R2";
      checks++;
      if (a_map[i] != e_map[i] || a_last[i] != e_last[i] || a_addr[i] != e_addr[i] ||
          a_data[i] != e_data[i] || a_cnt[i] != e_cnt[i]) begin
        fails++;
        $display("FAIL %s R3 %s beat %0d: act map=%0b last=%0b addr=%h data=%h cnt=%0d exp map=%0b last=%0b addr=%h data=%h cnt=%0d",
          rq, name, i, a_map[i], a_last[i], a_addr[i], a_data[i], a_cnt[i],
          e_map[i], e_last[i], e_addr[i], e_data[i], e_cnt[i]);
      end
    end
    n_act = 0; n_exp = 0;
  endtask

  task automatic test_reset();
    chk(s_ready == 1'b1, "R8", "s_ready after reset", int'(s_ready), 1);
    chk(m_valid == 1'b0, "R8", "m_valid after reset", int'(m_valid), 0);
  endtask

  task automatic test_one_tile();
    for (int i = 0; i < 3; i++) send(8 + i, 9 + i, 16'h0100 + 16'(i), 0);
    repeat (10) @(negedge clk);
    chk(n_act == 0, "R2", "no beats before group full", n_act, 0);
    for (int i = 3; i < 9; i++) send(8 + (i % 8), 15 - (i % 8), 16'h0100 + 16'(i), i == 8);
    compare("one_tile");
  endtask

  task automatic test_corners_eof_full();
    extra = "R8";
    send(63, 63, 16'hA063, 0);
    send(8, 0, 16'hA001, 0);
    send(0, 8, 16'hA008, 0);
    send(0, 0, 16'hB000, 0);
    send(7, 0, 16'hB001, 0);
    send(0, 7, 16'hB002, 0);
    send(7, 7, 16'hB003, 1);
    compare("corners");
    extra = "";
  endtask

  task automatic test_random_bp();
    int s = 12345;
    bp_on = 1;
    for (int i = 0; i < 150; i++) begin
      s = (s * 1103515245 + 12345) & 32'h7fffffff;
      send((s >> 4) & 63, (s >> 12) & 63, 16'((s >> 8) & 16'hFFFF), i == 149);
    end
    compare("random_backpressure");
    bp_on = 0;
    chk(r5_viol == 0, "R5", "input ready during burst", r5_viol, 0);
  endtask

  initial begin
    model_clear();
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    test_reset();
    test_one_tile();
    test_corners_eof_full();
    test_random_bp();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: act running exp done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule